// File: doc/BRIEF.md
# Video Line Counter with Frame Capture

This block counts horizontal sync pulses arriving on one of two asynchronous count pins and clears the count when an edge arrives on one of two asynchronous frame-reset pins. At each frame reset, the number of lines counted during the frame that just ended is latched into a capture register. A one-cycle strobe marks each capture, so software or a downstream block can read the line total per frame.

All four pins are resynchronised to the system clock. Per-function polarity bits choose whether a rising or a falling pin edge is the active one.

A guard window follows every frame reset and lasts at least 245 ns of system clock time. A count edge that lands inside this window is credited to the captured total of the frame that just ended. It is not counted in the new frame. This tolerates line pulses that trail the frame reset slightly. The live counter is 10 bits wide. It wraps from its top value to zero and raises a sticky overflow flag that lasts until the next frame reset.

Top module: `line_tally`

## Requirements
- R1: After `rst_n` is released, `line_count`, `frame_lines`, `capture_valid` and `overflow` are all 0.
- R2: Each active edge on the selected count pin increments `line_count` by one. The counter output changes on the third rising clock edge after the pin changes.
- R3: An active edge on the selected reset pin does four things in the same cycle: it copies the count into `frame_lines`, pulses `capture_valid` high for exactly one cycle, clears `line_count` to 0 and clears `overflow`.
- R4: For GUARD_CYC cycles after a capture, count edges increment `frame_lines` and leave `line_count` unchanged. GUARD_CYC is ceil(245 ns × CLK_HZ), which is 62 cycles at 250 MHz. After the window, count edges go to `line_count` again.
- R5: `cnt_sel` chooses the count pin: 0 selects `cnt_pin_a` and 1 selects `cnt_pin_b`. Edges on the unselected pin have no effect on `line_count`.
- R6: `cnt_rise` = 1 makes rising count-pin edges active. `cnt_rise` = 0 makes falling edges active, and the opposite edge is ignored.
- R7: `clr_sel` chooses the reset pin: 0 selects `clr_pin_a` and 1 selects `clr_pin_b`. `clr_rise` = 1 makes rising edges active and 0 makes falling edges active. Edges on the unselected reset pin do not capture.
- R8: A count edge at `line_count` = 0x3FF wraps the counter to 0 and sets `overflow`. The flag stays set until the next capture clears it.
- R9: When a count edge and a reset edge are detected in the same cycle, the reset wins. `frame_lines` receives the old count plus one, and `line_count` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_pin_a | input | 1 | Line pulse input A (asynchronous) |
| cnt_pin_b | input | 1 | Line pulse input B (asynchronous) |
| clr_pin_a | input | 1 | Frame reset input A (asynchronous) |
| clr_pin_b | input | 1 | Frame reset input B (asynchronous) |
| cnt_sel | input | 1 | Count pin select, 0 = A, 1 = B |
| clr_sel | input | 1 | Reset pin select, 0 = A, 1 = B |
| cnt_rise | input | 1 | Count edge polarity, 1 = rising, 0 = falling |
| clr_rise | input | 1 | Reset edge polarity, 1 = rising, 0 = falling |
| line_count | output | 10 | Live line count of the current frame |
| frame_lines | output | 10 | Line total captured at the last frame reset |
| capture_valid | output | 1 | One-cycle strobe when `frame_lines` is loaded |
| overflow | output | 1 | Sticky wrap flag, cleared at capture |

## Verification
The hardest cases to reach are the boundary of the guard window and the tie between a count edge and a reset edge. Both depend on which clock cycle the synchronised edges land in. The stimulus drives pins on falling clock edges, so the three-register path from pin to counter has a fixed latency. Counting cycles from the capture strobe then puts a line pulse at a chosen offset inside or outside the 62-cycle window. Raising a count pin and dropping a reset pin on the same falling edge makes both edges arrive in one cycle.

// File: rtl/line_tally.sv
module line_tally #(
  parameter int W        = 10,
  parameter int CLK_HZ   = 250_000_000,
  parameter int GUARD_NS = 245
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_pin_a,
  input  logic         cnt_pin_b,
  input  logic         clr_pin_a,
  input  logic         clr_pin_b,
  input  logic         cnt_sel,
  input  logic         clr_sel,
  input  logic         cnt_rise,
  input  logic         clr_rise,
  output logic [W-1:0] line_count,
  output logic [W-1:0] frame_lines,
  output logic         capture_valid,
  output logic         overflow
);
  localparam int GUARD_RAW = ((CLK_HZ / 1000) * GUARD_NS + 999_999) / 1_000_000;
  localparam int GUARD_CYC = (GUARD_RAW < 1) ? 1 : GUARD_RAW;
  localparam int GW        = $clog2(GUARD_CYC + 1);

  // polarity folded in ahead of the synchronisers: active edge is always a rise
  logic [3:0] lvl, s1, s2, s3, rise;
  assign lvl = {clr_pin_b ^ ~clr_rise, clr_pin_a ^ ~clr_rise,
                cnt_pin_b ^ ~cnt_rise, cnt_pin_a ^ ~cnt_rise};

  for (genvar i = 0; i < 4; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[i] <= 1'b0;
        s2[i] <= 1'b0;
        s3[i] <= 1'b0;
      end else begin
        s1[i] <= lvl[i];
        s2[i] <= s1[i];
        s3[i] <= s2[i];
      end
    end
    assign rise[i] = s2[i] & ~s3[i];
  end

  logic cnt_edge, clr_edge, guard_on;
  logic [GW-1:0] guard;
  assign cnt_edge = cnt_sel ? rise[1] : rise[0];
  assign clr_edge = clr_sel ? rise[3] : rise[2];
  assign guard_on = (guard != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_count    <= '0;
      frame_lines   <= '0;
      capture_valid <= 1'b0;
      overflow      <= 1'b0;
      guard         <= '0;
    end else begin
      capture_valid <= clr_edge;
      if (clr_edge) begin
        frame_lines <= line_count + W'(cnt_edge);
        line_count  <= '0;
        overflow    <= 1'b0;
        guard       <= GW'(GUARD_CYC);
      end else begin
        if (guard_on) guard <= guard - 1'b1;
        if (cnt_edge && guard_on) begin
          frame_lines <= frame_lines + 1'b1;
        end else if (cnt_edge) begin
          line_count <= line_count + 1'b1;
          if (line_count == '1) overflow <= 1'b1;
        end
      end
    end
  end

  assert_clear_on_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture_valid |-> (line_count == '0 && !overflow));
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture_valid |=> !capture_valid);
  assert_guard_holds_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_on && !clr_edge) |=> $stable(line_count));
  assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_count) |-> (line_count == '0 || line_count == W'($past(line_count) + 1'b1)));
  assert_wrap_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_edge && !guard_on && !clr_edge && line_count == '1) |=> (line_count == '0 && overflow));
  assert_tie_to_old_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_edge && clr_edge) |=> (frame_lines == W'($past(line_count) + 1'b1) && line_count == '0));
endmodule

// File: tb/sim_line_tally.sv
module sim_line_tally;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_pin_a = 0, cnt_pin_b = 0, clr_pin_a = 1, clr_pin_b = 0;
  logic cnt_sel = 0, clr_sel = 0, cnt_rise = 1, clr_rise = 0;
  logic [9:0] line_count, frame_lines;
  logic capture_valid, overflow;
  int vectors = 0, miscompares = 0;

  always #2 clk = ~clk;

  line_tally u0 (.clk(clk), .rst_n(rst_n), .cnt_pin_a(cnt_pin_a), .cnt_pin_b(cnt_pin_b),
    .clr_pin_a(clr_pin_a), .clr_pin_b(clr_pin_b), .cnt_sel(cnt_sel), .clr_sel(clr_sel),
    .cnt_rise(cnt_rise), .clr_rise(clr_rise), .line_count(line_count),
    .frame_lines(frame_lines), .capture_valid(capture_valid), .overflow(overflow));

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cnt(input bit ch, input logic v);
    if (ch) cnt_pin_b = v; else cnt_pin_a = v;
  endtask

  // pulse away from the idle level, 3 cycles each phase
  task automatic line_pulse(input bit ch, input logic idle);
    set_cnt(ch, ~idle); wait_n(3);
    set_cnt(ch, idle);  wait_n(3);
  endtask

  task automatic pulses(input bit ch, input logic idle, input int n);
    for (int i = 0; i < n; i++) line_pulse(ch, idle);
  endtask

  // drive reset pin A low (falling edge active), sample strobe, release
  task automatic frame_reset_a(input int exp_frame, input string tag);
    clr_pin_a = 0; wait_n(3);
    check({tag, " strobe"}, capture_valid, 1);
    check({tag, " frame"}, frame_lines, exp_frame);
    check({tag, " count"}, line_count, 0);
    clr_pin_a = 1; wait_n(1);
    check({tag, " strobe width"}, capture_valid, 0);
  endtask

  task automatic t_reset_state;
    check("R1 count", line_count, 0);
    check("R1 frame", frame_lines, 0);
    check("R1 valid", capture_valid, 0);
    check("R1 ovf", overflow, 0);
  endtask

  task automatic t_basic_count;
    line_pulse(0, 0);
    check("R2 first", line_count, 1);
    pulses(0, 0, 6);
    check("R2 seven", line_count, 7);
    cnt_pin_a = 1; wait_n(2);
    check("R2 latency before", line_count, 7);
    wait_n(1);
    check("R2 latency at", line_count, 8);
    cnt_pin_a = 0; wait_n(3);
  endtask

  task automatic t_capture;
    frame_reset_a(8, "R3");
    wait_n(80);
    check("R3 no re-strobe", capture_valid, 0);
  endtask

  task automatic t_guard;
    pulses(0, 0, 4);
    clr_pin_a = 0; wait_n(3);
    check("R4 capture", frame_lines, 4);
    clr_pin_a = 1;
    pulses(0, 0, 2);
    check("R4 guard frame", frame_lines, 6);
    check("R4 guard count", line_count, 0);
    wait_n(80);
    line_pulse(0, 0);
    check("R4 after guard count", line_count, 1);
    check("R4 after guard frame", frame_lines, 6);
    // window edge: capture at posedge t0+2.5, pulse at t0+k lands at capture+k
    clr_pin_a = 0; wait_n(3); clr_pin_a = 1;
    wait_n(52); line_pulse(0, 0);
    check("R4 k55 inside frame", frame_lines, 2);
    check("R4 k55 inside count", line_count, 0);
    wait_n(80);
    clr_pin_a = 0; wait_n(3); clr_pin_a = 1;
    wait_n(67); line_pulse(0, 0);
    check("R4 k70 outside frame", frame_lines, 0);
    check("R4 k70 outside count", line_count, 1);
    wait_n(20);
  endtask

  task automatic t_select_cnt;
    int base;
    base = line_count;
    cnt_sel = 1; wait_n(3);
    pulses(0, 0, 3);
    check("R5 unselected A", line_count, base);
    pulses(1, 0, 4);
    check("R5 selected B", line_count, base + 4);
    cnt_sel = 0; wait_n(3);
    pulses(1, 0, 2);
    check("R5 unselected B", line_count, base + 4);
  endtask

  task automatic t_polarity_cnt;
    int base;
    cnt_sel = 1; wait_n(3);
    cnt_pin_a = 1; wait_n(4);
    cnt_sel = 0; wait_n(4);
    cnt_rise = 0; wait_n(4);
    base = line_count;
    cnt_pin_a = 0; wait_n(3);
    check("R6 falling counted", line_count, base + 1);
    cnt_pin_a = 1; wait_n(3);
    check("R6 rising ignored", line_count, base + 1);
    pulses(0, 1, 3);
    check("R6 falling pulses", line_count, base + 4);
  endtask

  task automatic t_overflow;
    int i;
    i = 0;
    clr_pin_a = 0; wait_n(3); clr_pin_a = 1; wait_n(80);
    pulses(0, 1, 1023);
    check("R8 top", line_count, 1023);
    check("R8 no flag", overflow, 0);
    line_pulse(0, 1);
    check("R8 wrap", line_count, 0);
    check("R8 flag", overflow, 1);
    pulses(0, 1, 2);
    check("R8 sticky", overflow, 1);
    frame_reset_a(2, "R8 capture");
    check("R8 cleared", overflow, 0);
    wait_n(80);
  endtask

  task automatic t_tie;
    pulses(0, 1, 5);
    cnt_pin_a = 0; clr_pin_a = 0; wait_n(3);
    check("R9 strobe", capture_valid, 1);
    check("R9 frame", frame_lines, 6);
    check("R9 count", line_count, 0);
    cnt_pin_a = 1; clr_pin_a = 1; wait_n(80);
    check("R9 count after", line_count, 0);
  endtask

  task automatic t_select_clr;
    int f;
    pulses(0, 1, 3);
    clr_sel = 1; wait_n(3);
    clr_rise = 1; wait_n(4);
    f = frame_lines;
    clr_pin_a = 0; wait_n(3);
    check("R7 unselected A no strobe", capture_valid, 0);
    clr_pin_a = 1; wait_n(3);
    check("R7 unselected A frame", frame_lines, f);
    check("R7 unselected A count", line_count, 3);
    clr_pin_b = 1; wait_n(3);
    check("R7 B rising strobe", capture_valid, 1);
    check("R7 B rising frame", frame_lines, 3);
    clr_pin_b = 0; wait_n(3);
    check("R7 B falling ignored", frame_lines, 3);
    wait_n(80);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(3);
    t_reset_state();
    t_basic_count();
    t_capture();
    t_guard();
    t_select_cnt();
    t_polarity_cnt();
    t_overflow();
    t_tie();
    t_select_clr();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule